// File: doc/BRIEF.md
# Register-Mapped Nonvolatile Word Store Access Port

This block lets software read and write single 16-bit words of a 64-entry nonvolatile word store through two 32-bit registers, with no serial timing involved. Writing a command word to the fetch register, with its start bit set, looks up the addressed word. The same fetch register then returns the word, a completion flag and the address that was asked for. Writing a command word to the store register puts its upper half into the array. Completion of a store is also reported in the fetch register, never in the store register itself.

Two register layouts exist, chosen by the `LAYOUT` parameter. The legacy layout has a narrow address field placed high and the completion flag at bit 4. The wide layout has a 14-bit address field starting just above the completion flag at bit 1. In both layouts the data word sits in the upper half and the start bit is bit 0. Every access takes one clock cycle, and its result can be read in the next cycle.

Top module: `ee_reg_port`

## Requirements
- R1: After reset, both registers read as zero and every array word holds 16'hFFFF.
- R2: A fetch command that is valid sets the fetch register to: the stored word in bits [31:16], the completion flag, and the address echoed in its field.
- R3: With `LAYOUT` = legacy (0), the address field is bits [15:8] (8 bits) and the completion flag is bit 4.
- R4: With `LAYOUT` = wide (1), the address field is bits [15:2] (14 bits) and the completion flag is bit 1.
- R5: A command is valid only when bit 0 (start) is 1 and the address field value is below 64. For an invalid command of either kind, the fetch register shows zero data and a clear completion flag, with the address still echoed.
- R6: A valid store command writes bits [31:16] into the addressed word. The fetch register then shows the completion flag, the address and the written data.
- R7: An invalid store command leaves every array word unchanged.
- R8: The store register reads back the last value written to it, all 32 bits.
- R9: Command bits outside the start bit, the address field and (for stores) the data field have no effect. They read back as zero in the fetch register.
- R10: The register written at a clock edge can be read in the cycle right after it. The fetch register holds its value while no write occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one access per cycle |
| reg_sel | input | 1 | Register select: 0 = fetch register, 1 = store register |
| reg_wdata | input | 32 | Write data (command word) |
| reg_rdata | output | 32 | Read data of the selected register |

## Verification
The hardest cases to reach from the ports are the out-of-range commands whose low address bits alias a valid word, for example address 64 or a wide-layout address in the thousands. An array that indexes only the low bits would quietly corrupt word 0 or word 5 in those cases. The random stimulus draws addresses past the top of the array and fills all unused command bits with noise. Directed sequences then store to such an aliasing address and read back the word it would have hit. Both layouts run side by side in two instances, each with its own reference array in the bench.

// File: rtl/ee_port_pkg.sv
package ee_port_pkg;

    localparam int REG_W     = 32;
    localparam int DATA_W    = 16;
    localparam int DATA_LSB  = 16;
    localparam int START_BIT = 0;

    typedef enum logic {
        LAYOUT_LEGACY = 1'b0,
        LAYOUT_WIDE   = 1'b1
    } layout_e;

    typedef struct packed {
        logic [REG_W-1:0] fetch;
        logic [REG_W-1:0] store;
    } port_state_t;

    function automatic int addr_lsb(layout_e l);
        return (l == LAYOUT_LEGACY) ? 8 : 2;
    endfunction

    function automatic int addr_width(layout_e l);
        return (l == LAYOUT_LEGACY) ? 8 : 14;
    endfunction

    function automatic int done_pos(layout_e l);
        return (l == LAYOUT_LEGACY) ? 4 : 1;
    endfunction

endpackage

// File: rtl/ee_cmd_decode.sv
module ee_cmd_decode
    import ee_port_pkg::*;
#(
    parameter layout_e LAYOUT = LAYOUT_LEGACY,
    parameter int      WORDS  = 64,
    localparam int     IDX_W  = $clog2(WORDS)
) (
    input  logic [REG_W-1:0] cmd,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] echo,
    output logic [REG_W-1:0] done_flag
);

    localparam int A_LSB = addr_lsb(LAYOUT);
    localparam int A_W   = addr_width(LAYOUT);
    localparam int D_POS = done_pos(LAYOUT);

    logic [A_W-1:0] field;
    logic           in_range;

    assign field = cmd[A_LSB +: A_W];
    assign idx   = field[IDX_W-1:0];

    generate
        if (A_W > IDX_W) begin : g_upper_bits
            logic [A_W-IDX_W-1:0] upper;
            assign upper    = field[A_W-1:IDX_W];
            assign in_range = (upper == '0) && ({1'b0, idx} < (IDX_W+1)'(WORDS));
        end else begin : g_exact_bits
            assign in_range = ({1'b0, field} < (A_W+1)'(WORDS));
        end
    endgenerate

    assign hit = cmd[START_BIT] && in_range;

    always_comb begin
        echo                   = '0;
        echo[A_LSB +: A_W]     = field;
        done_flag              = '0;
        done_flag[D_POS]       = 1'b1;
    end

endmodule

// File: rtl/ee_word_array.sv
module ee_word_array #(
    parameter int              WORDS  = 64,
    parameter int              DATA_W = 16,
    parameter logic [DATA_W-1:0] ERASED = '1,
    localparam int             IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] word_q [WORDS];

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [DATA_W-1:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (we && (waddr == IDX_W'(g))) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q[g] <= ERASED;
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    assign rdata = word_q[raddr];

    // R6: a granted store lands in the addressed word
    assert_store_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (word_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/ee_reg_port.sv
module ee_reg_port
    import ee_port_pkg::*;
#(
    parameter layout_e           LAYOUT = LAYOUT_LEGACY,
    parameter int                WORDS  = 64,
    parameter logic [DATA_W-1:0] ERASED = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata
);

    localparam int  IDX_W     = $clog2(WORDS);
    localparam logic SEL_FETCH = 1'b0;
    localparam logic SEL_STORE = 1'b1;

    port_state_t       st_d, st_q;
    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [REG_W-1:0]  echo;
    logic [REG_W-1:0]  done_flag;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] cmd_data;
    logic              store_we;

    ee_cmd_decode #(
        .LAYOUT (LAYOUT),
        .WORDS  (WORDS)
    ) u_decode (
        .cmd       (reg_wdata),
        .hit       (hit),
        .idx       (idx),
        .echo      (echo),
        .done_flag (done_flag)
    );

    assign cmd_data = reg_wdata[DATA_LSB +: DATA_W];
    assign store_we = reg_wr && (reg_sel == SEL_STORE) && hit;

    ee_word_array #(
        .WORDS  (WORDS),
        .DATA_W (DATA_W),
        .ERASED (ERASED)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (store_we),
        .waddr (idx),
        .wdata (cmd_data),
        .raddr (idx),
        .rdata (rd_word)
    );

    always_comb begin
        logic [DATA_W-1:0] shown;
        st_d  = st_q;
        shown = (reg_sel == SEL_STORE) ? cmd_data : rd_word;
        if (reg_wr) begin
            if (reg_sel == SEL_STORE) begin
                st_d.store = reg_wdata;
            end
            st_d.fetch = echo;
            if (hit) begin
                st_d.fetch = echo | done_flag
                           | (REG_W'(shown) << DATA_LSB);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rdata = (reg_sel == SEL_STORE) ? st_q.store : st_q.fetch;

    // R2: a valid fetch returns the word the array held at that edge
    assert_fetch_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_FETCH && hit)
        |=> (st_q.fetch[DATA_LSB +: DATA_W] == $past(rd_word)));

    // R5: a refused command shows neither data nor completion
    assert_refused_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !hit)
        |=> ((st_q.fetch[DATA_LSB +: DATA_W] == '0) && ((st_q.fetch & done_flag) == '0)));

    // R8: the store register mirrors the last word written to it
    assert_store_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel == SEL_STORE) |=> (st_q.store == $past(reg_wdata)));

    // R10: no write, no change of the fetch register
    assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_wr |=> $stable(st_q.fetch));

endmodule

// File: tb/sim_ee_reg_port.sv
`timescale 1ns/1ps
module sim_ee_reg_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr0 = 1'b0, sel0 = 1'b0, wr1 = 1'b0, sel1 = 1'b0;
    logic [31:0] wd0 = '0, wd1 = '0;
    logic [31:0] rd0, rd1;

    int          n_checks = 0;
    int          n_fails  = 0;
    bit          finished = 0;

    logic [15:0] ref_mem [2][64];
    logic [31:0] ref_fetch [2];
    logic [31:0] ref_store [2];

    always #4 clk = ~clk;

    ee_reg_port #(.LAYOUT(ee_port_pkg::LAYOUT_LEGACY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_sel(sel0),
        .reg_wdata(wd0), .reg_rdata(rd0));

    ee_reg_port #(.LAYOUT(ee_port_pkg::LAYOUT_WIDE)) u1 (
        .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_sel(sel1),
        .reg_wdata(wd1), .reg_rdata(rd1));

    // instance 0: legacy (R3), instance 1: wide (R4)
    function automatic int lsb_of(int inst);  return inst == 0 ? 8 : 2;  endfunction
    function automatic int wid_of(int inst);  return inst == 0 ? 8 : 14; endfunction
    function automatic int done_of(int inst); return inst == 0 ? 4 : 1;  endfunction

    function automatic logic [31:0] make_cmd(int inst, logic start, int addr,
                                             logic [15:0] data, logic [31:0] noise);
        logic [31:0] c;
        logic [31:0] amask;
        amask = ((32'd1 << wid_of(inst)) - 1) << lsb_of(inst);
        c = noise & ~amask & 32'h0000_FFFE;
        c = c | ((32'(addr) << lsb_of(inst)) & amask) | {data, 16'h0} | 32'(start);
        return c;
    endfunction

    task automatic model(int inst, logic sel, logic [31:0] cmd);
        int  a;
        bit  ok;
        logic [15:0] d;
        a  = int'((cmd >> lsb_of(inst)) & ((32'd1 << wid_of(inst)) - 1));
        ok = cmd[0] && (a < 64);
        d  = sel ? cmd[31:16] : ref_mem[inst][a % 64];
        if (sel) ref_store[inst] = cmd;
        if (ok && sel) ref_mem[inst][a] = cmd[31:16];
        ref_fetch[inst] = 32'(a) << lsb_of(inst);
        if (ok) ref_fetch[inst] = ref_fetch[inst] | (32'd1 << done_of(inst)) | {d, 16'h0};
    endtask

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic peek(int inst, string tag);
        if (inst == 0) begin
            sel0 = 1'b0; #1; check({tag, " fetch u0"}, rd0, ref_fetch[0]);
            sel0 = 1'b1; #1; check("R8 store u0", rd0, ref_store[0]);
            sel0 = 1'b0;
        end else begin
            sel1 = 1'b0; #1; check({tag, " fetch u1"}, rd1, ref_fetch[1]);
            sel1 = 1'b1; #1; check("R8 store u1", rd1, ref_store[1]);
            sel1 = 1'b0;
        end
    endtask

    task automatic access(int inst, logic sel, logic [31:0] cmd, string tag);
        @(negedge clk);
        if (inst == 0) begin wr0 = 1'b1; sel0 = sel; wd0 = cmd; end
        else           begin wr1 = 1'b1; sel1 = sel; wd1 = cmd; end
        model(inst, sel, cmd);
        @(negedge clk);
        wr0 = 1'b0; wr1 = 1'b0;
        peek(inst, tag);
    endtask

    task automatic fetch(int inst, int addr, string tag);
        access(inst, 1'b0, make_cmd(inst, 1'b1, addr, 16'h0, $urandom()), tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL R10 watchdog actual=hung expected=complete");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            ref_fetch[i] = '0; ref_store[i] = '0;
            for (int w = 0; w < 64; w++) ref_mem[i][w] = 16'hFFFF;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        peek(0, "R1"); peek(1, "R1");
        for (int w = 0; w < 64; w++) begin
            fetch(0, w, "R1 erased");
            if (w % 9 == 0) fetch(1, w, "R1 erased");
        end

        // R2/R6/R3/R4: store then fetch at the array edges
        for (int i = 0; i < 2; i++) begin
            access(i, 1'b1, make_cmd(i, 1'b1, 63, 16'hA5C3, 32'h0), "R6 top");
            fetch(i, 63, "R2 top");
            access(i, 1'b1, make_cmd(i, 1'b1, 0, 16'h1234, 32'h0), "R6 zero");
            fetch(i, 0, "R2 zero");
        end

        // R5/R7: aliasing out-of-range store and refused start
        access(0, 1'b1, make_cmd(0, 1'b1, 64, 16'hDEAD, 32'h0), "R5 addr64");
        fetch(0, 0, "R7 alias0");
        access(1, 1'b1, make_cmd(1, 1'b1, 16384 - 59, 16'hBEEF, 32'h0), "R5 wide high");
        fetch(1, 5, "R7 alias5");
        access(0, 1'b1, make_cmd(0, 1'b0, 7, 16'h7777, 32'h0), "R5 nostart");
        fetch(0, 7, "R7 nostart");
        access(1, 1'b0, make_cmd(1, 1'b0, 9, 16'h0, 32'hFFFF_FFFF), "R5 fetch nostart");

        // R9: noise in unused bits
        access(0, 1'b1, make_cmd(0, 1'b1, 12, 16'h0F0F, 32'hFFFF_FFFF), "R9 noise");
        access(1, 1'b0, make_cmd(1, 1'b1, 12, 16'hFFFF, 32'hFFFF_FFFF), "R9 noise");

        // R10: fetch register holds while idle
        repeat (4) @(negedge clk);
        peek(0, "R10 hold"); peek(1, "R10 hold");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int inst;
            int a;
            inst = n % 2;
            if ($urandom_range(0, 9) == 0 && inst == 1) a = int'($urandom_range(64, 16383));
            else a = int'($urandom_range(0, 79));
            access(inst, 1'($urandom_range(0, 1)),
                   make_cmd(inst, ($urandom_range(0, 9) != 0), a,
                            16'($urandom()), $urandom()), "R2 R6 random");
        end

        // final sweep: array contents against the reference
        for (int i = 0; i < 2; i++)
            for (int w = 0; w < 64; w++) fetch(i, w, "R7 sweep");

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule